// File: doc/BRIEF.md
# One-Shot and Periodic Tick Timer Pair

This block holds two independent tick timers of configurable width (32 bits by default) behind a small register bus. One timer is a one-shot countdown and the other a periodic timer. Software arms a timer by writing an interval N to its control register. The timer then counts N ticks and emits a one-cycle expiry pulse. The one-shot then falls idle. The periodic timer reloads the same interval and keeps pulsing every N ticks. Writing zero disarms either timer. Every write restarts the interval from the cycle of the write and drops any expiry that was pending.

Time advances only on clock cycles where the tick enable input is high, so a prescaler outside the block sets the tick rate. Each timer also has a read-only register that reports how many ticks remain until its next expiry. Register data travels in big-endian byte order across the byte lanes of the bus. A register access of any size other than the full register width is refused and flagged on an error output.

Top module: `tick_timer_pair`

## Requirements
- R1: Register offsets (6-bit address): 0x20 one-shot control, 0x24 one-shot remaining, 0x28 periodic control, 0x2C periodic remaining. Reads of any other offset return zero. Writes to other offsets, or to the two remaining registers, change nothing.
- R2: An access to one of the four registers with `req_size` (number of bytes) other than 4 pulses `acc_err` for one cycle after the request. It gives no `rd_valid` and leaves the timer state unchanged.
- R3: Writing zero to a control register disarms that timer. It produces no expiry pulse afterwards, and its remaining register reads zero.
- R4: Writing nonzero N arms the timer. Its expiry output is high in the cycle after the N-th tick edge that follows the write edge. Any expiry pending from an earlier value is cancelled, even one due on the write edge itself.
- R5: Reading a control register returns the last value written to it.
- R6: Reading a remaining register returns the number of ticks still to elapse before the next expiry, or zero when the timer is idle.
- R7: The one-shot gives exactly one pulse per arming and then reads zero remaining. Its control register keeps N. The periodic timer pulses every N ticks until it is rewritten.
- R8: Timers advance only on clock edges where `tick_en` is high.
- R9: Byte order: bus bits [7:0] carry the most significant byte of a register value and bits [31:24] the least significant byte. This holds for both `req_wdata` and `rd_data`.
- R10: Reset clears both intervals and remaining counts to zero. Reset also holds every output low.
- R11: A read request with size 4 gives `rd_valid` high for one cycle, with `rd_data`, in the cycle after the request. A write never asserts `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Tick qualifier; a timer advances on edges where it is high |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, big-endian lanes |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, big-endian lanes |
| acc_err | output | 1 | Wrong-size access flag |
| oneshot_expire | output | 1 | One-shot expiry pulse |
| periodic_expire | output | 1 | Periodic expiry pulse |

## Verification
On every cycle the assertions check the following. A write loads the remaining count and suppresses any pulse. A zero write leaves a timer idle. Control registers hold between writes. Nothing moves while `tick_en` is low. At each expiry the one-shot empties and the periodic timer reloads its interval. A wrong-size access never reaches a timer. The exact cycle of each pulse relative to the write, the cancellation of a pulse that was due on the write edge, the lane ordering of data, and the values of unmapped reads can only be shown by the bench's scenarios, which compare them against counts derived from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned OFS_OS_CTRL = 'h20;
   localparam int unsigned OFS_OS_LEFT = 'h24;
   localparam int unsigned OFS_PT_CTRL = 'h28;
   localparam int unsigned OFS_PT_LEFT = 'h2C;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_OS_CTRL,
      SEL_OS_LEFT,
      SEL_PT_CTRL,
      SEL_PT_LEFT
   } reg_sel_e;
endpackage

// File: rtl/lane_swap.sv
module lane_swap #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LANES = DATA_W / 8
) (
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("lane_swap: DATA_W must be a whole number of bytes");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign dout[8*i +: 8] = din[8*(LANES-1-i) +: 8];
   end
endmodule

// File: rtl/reg_decode.sv
module reg_decode
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned FULL_BYTES = DATA_W / 8
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size,
   output reg_sel_e          sel,
   output logic              size_bad,
   output logic              wr_os,
   output logic              wr_pt,
   output logic              rd_ok
);
   if (ADDR_W < 6) begin : g_bad_addr
      $error("reg_decode: ADDR_W too small for the register offsets");
   end

   always_comb begin
      unique case (int'(req_addr))
         OFS_OS_CTRL: sel = SEL_OS_CTRL;
         OFS_OS_LEFT: sel = SEL_OS_LEFT;
         OFS_PT_CTRL: sel = SEL_PT_CTRL;
         OFS_PT_LEFT: sel = SEL_PT_LEFT;
         default:     sel = SEL_NONE;
      endcase
   end

   logic size_full;
   assign size_full = (int'(req_size) == FULL_BYTES);
   assign size_bad  = req_valid && (sel != SEL_NONE) && !size_full;
   assign wr_os     = req_valid && req_write && size_full && (sel == SEL_OS_CTRL);
   assign wr_pt     = req_valid && req_write && size_full && (sel == SEL_PT_CTRL);
   assign rd_ok     = req_valid && !req_write && !size_bad;
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
   parameter int unsigned CNT_W    = 32,
   parameter bit          PERIODIC = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] interval_o,
   output logic [CNT_W-1:0] remaining_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("tick_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] reload_val;

   if (PERIODIC) begin : g_periodic
      assign reload_val = interval_o;
   end else begin : g_oneshot
      assign reload_val = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         interval_o  <= '0;
         remaining_o <= '0;
         expire_o    <= 1'b0;
      end else begin
         expire_o <= 1'b0;
         if (wr_en) begin
            interval_o  <= wr_val;
            remaining_o <= wr_val;
         end else if (tick_en && remaining_o != '0) begin
            if (remaining_o == ONE) begin
               expire_o    <= 1'b1;
               remaining_o <= reload_val;
            end else begin
               remaining_o <= remaining_o - ONE;
            end
         end
      end
   end

   AST_ZERO_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_val == '0 |=> remaining_o == '0 && !expire_o); // R3
   AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> remaining_o == $past(wr_val) && !expire_o); // R4
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(interval_o)); // R5
   AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en && !wr_en |=> $stable(remaining_o) && !expire_o); // R8

   if (PERIODIC) begin : g_chk_periodic
      AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
         expire_o |-> remaining_o == interval_o && interval_o != '0); // R7
   end else begin : g_chk_oneshot
      AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
         expire_o |-> remaining_o == '0); // R7
   end
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              acc_err,
   output logic              oneshot_expire,
   output logic              periodic_expire
);
   if (DATA_W % 8 != 0 || DATA_W > 56) begin : g_bad_data
      $error("tick_timer_pair: DATA_W must be whole bytes and at most 7 bytes");
   end

   reg_sel_e         sel;
   logic             size_bad, wr_os, wr_pt, rd_ok;
   logic [DATA_W-1:0] wval, rval, rlanes;
   logic [DATA_W-1:0] os_int, os_left, pt_int, pt_left;

   reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_size  (req_size),
      .sel       (sel),
      .size_bad  (size_bad),
      .wr_os     (wr_os),
      .wr_pt     (wr_pt),
      .rd_ok     (rd_ok)
   );

   lane_swap #(.DATA_W(DATA_W)) u_wswap (.din(req_wdata), .dout(wval));

   tick_counter #(.CNT_W(DATA_W), .PERIODIC(1'b0)) u_oneshot (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en     (tick_en),
      .wr_en       (wr_os),
      .wr_val      (wval),
      .interval_o  (os_int),
      .remaining_o (os_left),
      .expire_o    (oneshot_expire)
   );

   tick_counter #(.CNT_W(DATA_W), .PERIODIC(1'b1)) u_periodic (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en     (tick_en),
      .wr_en       (wr_pt),
      .wr_val      (wval),
      .interval_o  (pt_int),
      .remaining_o (pt_left),
      .expire_o    (periodic_expire)
   );

   always_comb begin
      unique case (sel)
         SEL_OS_CTRL: rval = os_int;
         SEL_OS_LEFT: rval = os_left;
         SEL_PT_CTRL: rval = pt_int;
         SEL_PT_LEFT: rval = pt_left;
         default:     rval = '0;
      endcase
   end

   lane_swap #(.DATA_W(DATA_W)) u_rswap (.din(rval), .dout(rlanes));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         acc_err  <= 1'b0;
      end else begin
         rd_valid <= rd_ok;
         acc_err  <= size_bad;
         if (rd_ok) rd_data <= rlanes;
      end
   end

   AST_BAD_SIZE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      size_bad |-> !wr_os && !wr_pt); // R2
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      size_bad |=> acc_err && !rd_valid); // R2
   AST_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && int'(req_size) == DATA_W / 8 |=> rd_valid); // R11
   AST_WRITE_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write |=> !rd_valid); // R11
endmodule

// File: tb/sim_tick_timer_pair.sv
`timescale 1ns/100ps
module sim_tick_timer_pair;
   localparam real HALF = 2.5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [5:0]  req_addr = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        rd_valid, acc_err, oneshot_expire, periodic_expire;
   logic [31:0] rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(HALF) clk = ~clk;

   tick_timer_pair u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
      .oneshot_expire(oneshot_expire), .periodic_expire(periodic_expire)
   );

   // R9: most significant byte travels in lanes [7:0]
   function automatic logic [31:0] be(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic acc(input bit w, input logic [5:0] a, input logic [2:0] sz,
                      input logic [31:0] v);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz;
      req_wdata = be(v);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd_expect(input logic [5:0] a, input logic [31:0] exp,
                            input string req);
      acc(1'b0, a, 3'd4, 32'h0);
      chk(rd_valid && be(rd_data) == exp, req, be(rd_data), exp);
   endtask

   task automatic watch(input bit per, input int n, input int cycles,
                        input string req);
      for (int i = 1; i <= cycles; i++) begin
         logic got, want;
         @(negedge clk);
         got  = per ? periodic_expire : oneshot_expire;
         want = (n != 0) && (per ? (i % n == 0) : (i == n));
         chk(got == want, req, 32'(got), 32'(want));
      end
   endtask

   typedef struct packed {
      logic        w;
      logic [5:0]  a;
      logic [2:0]  sz;
      logic [31:0] v;
      logic        err;
      logic [31:0] rd;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 6'h20, 3'd4, 32'h1234_5678, 1'b0, 32'h0},           // R1
      '{1'b0, 6'h20, 3'd4, 32'h0,         1'b0, 32'h1234_5678},   // R5
      '{1'b1, 6'h28, 3'd4, 32'h0000_00C8, 1'b0, 32'h0},
      '{1'b0, 6'h28, 3'd4, 32'h0,         1'b0, 32'h0000_00C8},   // R5
      '{1'b1, 6'h20, 3'd2, 32'h0000_FFFF, 1'b1, 32'h0},           // R2
      '{1'b0, 6'h20, 3'd4, 32'h0,         1'b0, 32'h1234_5678},   // R2
      '{1'b0, 6'h24, 3'd1, 32'h0,         1'b1, 32'h0},           // R2
      '{1'b0, 6'h24, 3'd4, 32'h0,         1'b0, 32'h1234_5678},   // R6
      '{1'b1, 6'h24, 3'd4, 32'hAAAA_AAAA, 1'b0, 32'h0},           // R1
      '{1'b0, 6'h24, 3'd4, 32'h0,         1'b0, 32'h1234_5678},   // R1
      '{1'b0, 6'h30, 3'd4, 32'h0,         1'b0, 32'h0},           // R1
      '{1'b1, 6'h00, 3'd4, 32'h0000_0055, 1'b0, 32'h0},           // R1
      '{1'b1, 6'h20, 3'd4, 32'h0,         1'b0, 32'h0},           // R3
      '{1'b0, 6'h24, 3'd4, 32'h0,         1'b0, 32'h0}            // R3
   };

   initial begin
      #(HALF * 2 * 100000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!rd_valid && !acc_err && !oneshot_expire && !periodic_expire,
          "R10 outputs in reset", 32'({rd_valid, acc_err, oneshot_expire, periodic_expire}), 0);
      rst_n = 1'b1;
      rd_expect(6'h20, 32'h0, "R10 one-shot interval after reset");
      rd_expect(6'h2C, 32'h0, "R10 periodic remaining after reset");

      // table walk with tick_en low: R1 R2 R5 R6 R11
      for (int k = 0; k < NV; k++) begin
         acc(VEC[k].w, VEC[k].a, VEC[k].sz, VEC[k].v);
         chk(acc_err == VEC[k].err, "R2 err flag", 32'(acc_err), 32'(VEC[k].err));
         if (VEC[k].w || VEC[k].err)
            chk(!rd_valid, "R11 no rd_valid", 32'(rd_valid), 0);
         else
            chk(rd_valid && be(rd_data) == VEC[k].rd, "R1 R5 R6 read vector",
                be(rd_data), VEC[k].rd);
      end

      // R9: raw lane check
      acc(1'b1, 6'h20, 3'd4, 32'h1234_5678);
      acc(1'b0, 6'h20, 3'd4, 32'h0);
      chk(rd_data[7:0] == 8'h12 && rd_data[31:24] == 8'h78, "R9 lane order",
          rd_data, 32'h7856_3412);

      // R8: no ticks, no progress
      acc(1'b1, 6'h20, 3'd4, 32'd2);
      watch(1'b0, 0, 20, "R8 no pulse without ticks");
      rd_expect(6'h24, 32'd2, "R8 remaining frozen");

      // R6: three ticks from ten
      acc(1'b1, 6'h20, 3'd4, 32'd10);
      @(negedge clk); tick_en = 1'b1;
      repeat (3) @(negedge clk);
      tick_en = 1'b0;
      rd_expect(6'h24, 32'd7, "R6 remaining after 3 ticks");

      // R4 / R7: one-shot N=2
      tick_en = 1'b1;
      acc(1'b1, 6'h20, 3'd4, 32'd2);
      watch(1'b0, 2, 6, "R4 R7 one-shot pulse timing");
      tick_en = 1'b0;
      rd_expect(6'h24, 32'd0, "R7 one-shot remaining after expiry");
      rd_expect(6'h20, 32'd2, "R7 one-shot interval kept");

      // R4: rewrite cancels a pulse due on the write edge
      tick_en = 1'b1;
      acc(1'b1, 6'h20, 3'd4, 32'd5);
      watch(1'b0, 0, 3, "R4 no early pulse");
      acc(1'b1, 6'h20, 3'd4, 32'd4);
      watch(1'b0, 4, 8, "R4 restart from rewrite");

      // R7 periodic N=3, then R3 disarm
      acc(1'b1, 6'h28, 3'd4, 32'd3);
      watch(1'b1, 3, 10, "R7 periodic pulses");
      acc(1'b1, 6'h28, 3'd4, 32'd0);
      watch(1'b1, 0, 8, "R3 periodic disarmed");
      tick_en = 1'b0;
      rd_expect(6'h2C, 32'd0, "R3 remaining zero after disarm");

      // R2: wrong-size write does not rearm
      acc(1'b1, 6'h28, 3'd3, 32'd1);
      chk(acc_err, "R2 err on 3-byte write", 32'(acc_err), 1);
      tick_en = 1'b1;
      watch(1'b1, 0, 4, "R2 wrong-size write ignored");
      tick_en = 1'b0;

      // R10: reset mid-run
      acc(1'b1, 6'h28, 3'd4, 32'd9);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd_expect(6'h28, 32'd0, "R10 interval cleared by reset");
      rd_expect(6'h2C, 32'd0, "R10 remaining cleared by reset");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule